// File: doc/BRIEF.md
# Thread Block Dispatcher

The dispatcher accepts a one-dimensional launch (an element count and a thread count per block, plus the register and shared-memory cost of one block) and places whole thread blocks onto a small array of compute units. Each compute unit keeps its own free register pool and free shared-memory pool. A block is admitted to a unit only when both pools cover its cost. The dispatcher gives back a block's allocation when a completion pulse arrives for it.

Blocks leave in ascending index order, one at a time. For every placed block, the dispatcher then streams one descriptor per 32-thread warp. Each descriptor carries the global index of the warp's lane 0 and a lane-valid mask, so that threads beyond the element count stay idle. When every block has been placed and reported complete, the dispatcher pulses a launch-complete flag and returns to idle.

The controller has four states:
- IDLE waits for a request. It goes to PICK on an accepted launch and stays in IDLE on a rejected one.
- PICK looks for a unit for the next block. It goes to WARPS when it places a block and to DRAIN when no blocks remain. It stays in PICK, stalled, while no unit fits.
- WARPS streams the warp descriptors and returns to PICK after the last one.
- DRAIN waits for outstanding completions and returns to IDLE when they are all in.

Top module: `blk_dispatch`

## Requirements
- R1: A launch whose thread count is zero or not a multiple of 32 is rejected in the same cycle: `launch_err` is high and `launch_ready` stays high. The same applies when the register or shared-memory cost of a block exceeds one unit's capacity.
- R2: An accepted launch places exactly ceil(N / threads) blocks. `place_blk` counts up from 0 in steps of 1.
- R3: Each placement is followed, in the next cycle, by threads/32 warp descriptors, with `warp_idx` running 0, 1, and so on. No placement happens while descriptors are being streamed.
- R4: `warp_base` equals block index × threads + 32 × warp index.
- R5: Bit k of `warp_mask` (bit 0 = lane 0) is set exactly when `warp_base` + k < N. The mask is always a contiguous run starting at lane 0, and it can be zero for warps wholly past N.
- R6: A block is placed on the lowest-numbered unit whose free registers and free shared memory both cover the block's cost. The placement takes that cost from the unit's pools.
- R7: When no unit can take the next block, nothing is placed and no later block is placed ahead of it.
- R8: An accepted completion pulse returns the block's cost to its unit at that clock edge. A stalled block can therefore be placed on that unit in the very next cycle.
- R9: A completion pulse is ignored when no launch is active, when its block index is not below the number of blocks placed so far, or when its unit holds no block.
- R10: `launch_done` pulses for one cycle once all blocks are placed and completed. `launch_ready` is high in the cycle after. A launch with N = 0 places nothing and completes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_valid | input | 1 | Launch request present |
| launch_n | input | CNT_W | Element count N |
| launch_tpb | input | TPB_W | Threads per block |
| launch_regs | input | REG_W | Registers needed by one block |
| launch_smem | input | SMEM_W | Shared memory needed by one block |
| launch_ready | output | 1 | Dispatcher idle, request can be taken |
| launch_err | output | 1 | Request rejected (R1) |
| place_valid | output | 1 | A block is placed this cycle |
| place_cu | output | CU_W | Unit receiving the block |
| place_blk | output | BLK_W | Index of the placed block |
| warp_valid | output | 1 | Warp descriptor valid |
| warp_idx | output | WARP_W | Warp number within the block |
| warp_base | output | BASE_W | Global index of lane 0 |
| warp_mask | output | 32 | Lane-valid mask |
| done_valid | input | 1 | Block completion pulse |
| done_cu | input | CU_W | Unit that finished |
| done_blk | input | BLK_W | Block that finished |
| launch_done | output | 1 | All blocks of the launch completed |

## Verification
Some properties are checked by assertions on every cycle:
- a rejected request leaves the dispatcher idle;
- placement indices count up without gaps;
- a placement is followed at once by warp 0, and no placement overlaps descriptor streaming;
- every mask is a prefix of lanes;
- the launch-complete pulse returns the dispatcher to idle.

The bench's scenarios cover the rest. It checks the exact bases and masks against a scoreboard, and it predicts the chosen unit from its own model of the free pools. It also shows three stall behaviours: the stall while every unit is full, the placement in the cycle right after a completion, and the ignoring of a completion that names a block not yet placed.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PICK  = 2'd1,
        ST_WARPS = 2'd2,
        ST_DRAIN = 2'd3
    } disp_state_t;

    localparam int LANES = 32;
endpackage

// File: rtl/cu_pool.sv
module cu_pool #(
    parameter int NUM_CU   = 4,
    parameter int REG_CAP  = 4096,
    parameter int SMEM_CAP = 2048,
    parameter int REG_W    = 13,
    parameter int SMEM_W   = 12,
    parameter int CU_W     = 2,
    parameter int LIVE_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  need_regs,
    input  logic [SMEM_W-1:0] need_smem,
    input  logic              alloc_en,
    input  logic              rel_en,
    input  logic [CU_W-1:0]   rel_cu,
    output logic              fit_any,
    output logic [CU_W-1:0]   fit_cu,
    output logic [NUM_CU-1:0] busy
);
    localparam logic [REG_W-1:0]  REG_FULL  = REG_W'(REG_CAP);
    localparam logic [SMEM_W-1:0] SMEM_FULL = SMEM_W'(SMEM_CAP);

    logic [NUM_CU-1:0] fits;

    generate
        for (genvar u = 0; u < NUM_CU; u++) begin : g_unit
            logic [REG_W-1:0]  free_r;
            logic [SMEM_W-1:0] free_s;
            logic [LIVE_W-1:0] live;
            logic              take, give;

            assign fits[u] = (free_r >= need_regs) && (free_s >= need_smem);
            assign take    = alloc_en && (fit_cu == CU_W'(u));
            assign give    = rel_en && (rel_cu == CU_W'(u));
            assign busy[u] = (live != '0);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    free_r <= REG_FULL;
                    free_s <= SMEM_FULL;
                    live   <= '0;
                end else begin
                    free_r <= free_r + (give ? need_regs : '0) - (take ? need_regs : '0);
                    free_s <= free_s + (give ? need_smem : '0) - (take ? need_smem : '0);
                    live   <= live + LIVE_W'(take) - LIVE_W'(give);
                end
            end
        end
    endgenerate

    always_comb begin
        fit_any = |fits;
        fit_cu  = '0;
        for (int i = NUM_CU - 1; i >= 0; i--) begin
            if (fits[i]) fit_cu = CU_W'(i);
        end
    end
endmodule

// File: rtl/warp_mask_gen.sv
module warp_mask_gen #(
    parameter int CNT_W  = 16,
    parameter int BASE_W = 17
) (
    input  logic [BASE_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    output logic [31:0]       mask
);
    generate
        for (genvar l = 0; l < blk_dispatch_pkg::LANES; l++) begin : g_lane
            assign mask[l] = (base + BASE_W'(l)) < BASE_W'(count);
        end
    endgenerate
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
    import blk_dispatch_pkg::*;
#(
    parameter int NUM_CU   = 4,
    parameter int CNT_W    = 16,
    parameter int TPB_W    = 11,
    parameter int REG_CAP  = 4096,
    parameter int SMEM_CAP = 2048,
    parameter int REG_W    = $clog2(REG_CAP + 1),
    parameter int SMEM_W   = $clog2(SMEM_CAP + 1),
    parameter int CU_W     = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
    parameter int BLK_W    = CNT_W,
    parameter int WARP_W   = TPB_W - 5,
    parameter int BASE_W   = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    input  logic [CNT_W-1:0]  launch_n,
    input  logic [TPB_W-1:0]  launch_tpb,
    input  logic [REG_W-1:0]  launch_regs,
    input  logic [SMEM_W-1:0] launch_smem,
    output logic              launch_ready,
    output logic              launch_err,
    output logic              place_valid,
    output logic [CU_W-1:0]   place_cu,
    output logic [BLK_W-1:0]  place_blk,
    output logic              warp_valid,
    output logic [WARP_W-1:0] warp_idx,
    output logic [BASE_W-1:0] warp_base,
    output logic [31:0]       warp_mask,
    input  logic              done_valid,
    input  logic [CU_W-1:0]   done_cu,
    input  logic [BLK_W-1:0]  done_blk,
    output logic              launch_done
);
    localparam logic [REG_W-1:0]  REG_LIM  = REG_W'(REG_CAP);
    localparam logic [SMEM_W-1:0] SMEM_LIM = SMEM_W'(SMEM_CAP);
    localparam logic [CU_W:0]     CU_LIM   = (CU_W+1)'(NUM_CU);

    disp_state_t state, state_nx;

    logic [CNT_W-1:0]  n_q;
    logic [TPB_W-1:0]  tpb_q;
    logic [REG_W-1:0]  regs_q;
    logic [SMEM_W-1:0] smem_q;
    logic [BASE_W-1:0] next_base_q, wbase_q;
    logic [BLK_W-1:0]  blk_q, fin_q;
    logic [WARP_W-1:0] warp_q;

    logic bad_req, accept, more, place, last_warp, done_ok, all_fin;
    logic fit_any;
    logic [CU_W-1:0]   fit_cu;
    logic [NUM_CU-1:0] busy;

    assign bad_req   = (launch_tpb[4:0] != 5'd0) || (launch_tpb == '0)
                     || (launch_regs > REG_LIM) || (launch_smem > SMEM_LIM);
    assign accept    = (state == ST_IDLE) && launch_valid && !bad_req;
    assign more      = next_base_q < BASE_W'(n_q);
    assign place     = (state == ST_PICK) && more && fit_any;
    assign last_warp = (warp_q == (tpb_q[TPB_W-1:5] - WARP_W'(1)));
    assign done_ok   = (state != ST_IDLE) && done_valid && ({1'b0, done_cu} < CU_LIM)
                     && (done_blk < blk_q) && busy[done_cu];
    assign all_fin   = (fin_q == blk_q);

    cu_pool #(
        .NUM_CU(NUM_CU), .REG_CAP(REG_CAP), .SMEM_CAP(SMEM_CAP),
        .REG_W(REG_W), .SMEM_W(SMEM_W), .CU_W(CU_W), .LIVE_W(BLK_W)
    ) u_pool (
        .clk(clk), .rst_n(rst_n),
        .need_regs(regs_q), .need_smem(smem_q),
        .alloc_en(place), .rel_en(done_ok), .rel_cu(done_cu),
        .fit_any(fit_any), .fit_cu(fit_cu), .busy(busy)
    );

    warp_mask_gen #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_mask (
        .base(wbase_q), .count(n_q), .mask(warp_mask)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_PICK;
            ST_PICK:  if (!more) state_nx = ST_DRAIN;
                      else if (place) state_nx = ST_WARPS;
            ST_WARPS: if (last_warp) state_nx = ST_PICK;
            ST_DRAIN: if (all_fin) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0; tpb_q <= '0; regs_q <= '0; smem_q <= '0;
            next_base_q <= '0; wbase_q <= '0;
            blk_q <= '0; fin_q <= '0; warp_q <= '0;
        end else begin
            if (accept) begin
                n_q         <= launch_n;
                tpb_q       <= launch_tpb;
                regs_q      <= launch_regs;
                smem_q      <= launch_smem;
                next_base_q <= '0;
                blk_q       <= '0;
                fin_q       <= '0;
            end
            if (place) begin
                wbase_q     <= next_base_q;
                next_base_q <= next_base_q + BASE_W'(tpb_q);
                blk_q       <= blk_q + BLK_W'(1);
                warp_q      <= '0;
            end else if (state == ST_WARPS) begin
                warp_q  <= warp_q + WARP_W'(1);
                wbase_q <= wbase_q + BASE_W'(32);
            end
            if (done_ok) fin_q <= fin_q + BLK_W'(1);
        end
    end

    // outputs
    always_comb begin
        launch_ready = (state == ST_IDLE);
        launch_err   = (state == ST_IDLE) && launch_valid && bad_req;
        place_valid  = place;
        place_cu     = fit_cu;
        place_blk    = blk_q;
        warp_valid   = (state == ST_WARPS);
        warp_idx     = warp_q;
        warp_base    = wbase_q;
        launch_done  = (state == ST_DRAIN) && all_fin;
    end
endmodule

// File: rtl/blk_dispatch_chk.sv
module blk_dispatch_chk #(
    parameter int BLK_W  = 16,
    parameter int WARP_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch_valid,
    input logic              launch_ready,
    input logic              launch_err,
    input logic              place_valid,
    input logic [BLK_W-1:0]  place_blk,
    input logic              warp_valid,
    input logic [WARP_W-1:0] warp_idx,
    input logic [31:0]       warp_mask,
    input logic              launch_done
);
    logic [BLK_W-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= '0;
        else if (launch_valid && launch_ready && !launch_err) seen <= '0;
        else if (place_valid) seen <= seen + BLK_W'(1);
    end

    a_r1_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |-> launch_ready);
    a_r1_err_stays: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |=> launch_ready);
    a_r2_blk_order: assert property (@(posedge clk) disable iff (!rst_n)
        place_valid |-> (place_blk == seen));
    a_r3_first_warp: assert property (@(posedge clk) disable iff (!rst_n)
        place_valid |=> (warp_valid && warp_idx == '0));
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> !place_valid);
    a_r5_prefix_mask: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> ((warp_mask & (warp_mask + 32'd1)) == 32'd0));
    a_r10_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        launch_done |=> (launch_ready && !warp_valid));
endmodule

bind blk_dispatch blk_dispatch_chk #(.BLK_W(BLK_W), .WARP_W(WARP_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready), .launch_err(launch_err),
    .place_valid(place_valid), .place_blk(place_blk),
    .warp_valid(warp_valid), .warp_idx(warp_idx), .warp_mask(warp_mask),
    .launch_done(launch_done)
);

// File: tb/sim_blk_dispatch.sv
module sim_blk_dispatch;
    localparam int PERIOD = 10;
    localparam int NCU = 4;
    localparam int RCAP = 4096;
    localparam int SCAP = 2048;

    logic clk = 0, rst_n = 0;
    logic launch_valid = 0;
    logic [15:0] launch_n = 0;
    logic [10:0] launch_tpb = 0;
    logic [12:0] launch_regs = 0;
    logic [11:0] launch_smem = 0;
    logic launch_ready, launch_err, place_valid, warp_valid, launch_done;
    logic [1:0] place_cu;
    logic [15:0] place_blk;
    logic [5:0] warp_idx;
    logic [16:0] warp_base;
    logic [31:0] warp_mask;
    logic done_valid = 0;
    logic [1:0] done_cu = 0;
    logic [15:0] done_blk = 0;

    always #(PERIOD/2) clk = ~clk;

    blk_dispatch u0 (.*);

    int nchk = 0, nfail = 0;

    typedef struct { int blk; int idx; int base; logic [31:0] mask; } warp_t;
    warp_t exp_q[$];
    int pl_cu[$], pl_blk[$];

    int mfree_r[NCU], mfree_s[NCU], mlive[NCU];
    int pcount = 0, cur_r = 0, cur_s = 0;
    bit active = 0, saw_done = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (launch_valid && launch_ready && !launch_err) begin
                pcount = 0; active = 1; saw_done = 0;
                cur_r = int'(launch_regs); cur_s = int'(launch_smem);
            end
            if (place_valid) begin
                int pred;
                pred = -1;
                for (int i = NCU - 1; i >= 0; i--)
                    if (mfree_r[i] >= cur_r && mfree_s[i] >= cur_s) pred = i;
                chk(int'(place_cu) == pred, "R6", "unit chosen", int'(place_cu), pred);
                chk(int'(place_blk) == pcount, "R2", "block index", int'(place_blk), pcount);
                if (pred >= 0) begin
                    mfree_r[pred] -= cur_r; mfree_s[pred] -= cur_s; mlive[pred]++;
                end
                pl_cu.push_back(int'(place_cu));
                pl_blk.push_back(int'(place_blk));
                pcount++;
            end
            if (done_valid && active && int'(done_blk) < pcount && mlive[done_cu] > 0) begin
                mfree_r[done_cu] += cur_r; mfree_s[done_cu] += cur_s; mlive[done_cu]--;
            end
            if (warp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected warp", int'(warp_idx), -1);
                end else begin
                    warp_t e;
                    e = exp_q.pop_front();
                    chk(int'(warp_idx) == e.idx, "R3", "warp index", int'(warp_idx), e.idx);
                    chk(int'(warp_base) == e.base, "R4", "warp base", int'(warp_base), e.base);
                    chk(warp_mask == e.mask, "R5", "lane mask", int'(warp_mask), int'(e.mask));
                end
            end
            if (launch_done) begin
                saw_done = 1; active = 0;
            end
        end
    end

    task automatic push_expect(int n, int tpb);
        int nb;
        nb = (n + tpb - 1) / tpb;
        for (int b = 0; b < nb; b++) begin
            for (int w = 0; w < tpb / 32; w++) begin
                warp_t e;
                e.blk = b; e.idx = w; e.base = b * tpb + 32 * w;
                for (int l = 0; l < 32; l++) e.mask[l] = (e.base + l < n);
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic launch(int n, int tpb, int r, int s, bit expect_err);
        @(posedge clk); #1;
        launch_valid = 1; launch_n = 16'(n); launch_tpb = 11'(tpb);
        launch_regs = 13'(r); launch_smem = 12'(s);
        @(negedge clk);
        chk(launch_err == expect_err, "R1", "launch_err", int'(launch_err), int'(expect_err));
        @(posedge clk); #1;
        launch_valid = 0;
        if (expect_err) begin
            @(negedge clk);
            chk(launch_ready == 1'b1, "R1", "ready after reject", int'(launch_ready), 1);
        end
    endtask

    task automatic retire(int cu, int blk);
        @(posedge clk); #1;
        done_valid = 1; done_cu = 2'(cu); done_blk = 16'(blk);
        @(posedge clk); #1;
        done_valid = 0;
    endtask

    task automatic drain_all();
        int guard;
        guard = 0;
        while (!saw_done && guard < 5000) begin
            if (pl_cu.size() > 0) retire(pl_cu.pop_front(), pl_blk.pop_front());
            else @(negedge clk);
            guard++;
        end
        chk(saw_done, "R10", "launch_done seen", int'(saw_done), 1);
        @(negedge clk);
        chk(launch_ready == 1'b1, "R10", "ready after done", int'(launch_ready), 1);
        chk(exp_q.size() == 0, "R3", "warps left over", exp_q.size(), 0);
    endtask

    task automatic run_plain(int n, int tpb, int r, int s, int nblk);
        push_expect(n, tpb);
        launch(n, tpb, r, s, 0);
        drain_all();
        chk(pcount == nblk, "R2", "block count", pcount, nblk);
    endtask

    initial begin
        #(PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCU; i++) begin
            mfree_r[i] = RCAP; mfree_s[i] = SCAP; mlive[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(launch_ready && !place_valid && !warp_valid && !launch_done, "R10",
            "reset state", int'(launch_ready), 1);

        // R1 rejections
        launch(100, 48, 10, 10, 1);
        launch(100, 0, 10, 10, 1);
        launch(100, 64, 5000, 10, 1);
        launch(100, 64, 10, 3000, 1);

        // R2 R4 R5: partial last block, several blocks on unit 0
        run_plain(300, 128, 1000, 100, 3);
        // R5: one big block, last warp partial
        run_plain(1000, 1024, 100, 100, 1);
        // R6: shared-memory limited, one block per unit
        run_plain(128, 32, 10, 1500, 4);
        // R10: empty launch
        run_plain(0, 64, 10, 10, 0);

        // R7 R8 R9: stall with every unit full
        push_expect(320, 64);
        launch(320, 64, 3000, 100, 0);
        begin
            int g;
            g = 0;
            while (pcount < 4 && g < 200) begin @(negedge clk); g++; end
        end
        repeat (8) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!place_valid, "R7", "no placement while full", int'(place_valid), 0);
        end
        retire(2, 9);
        repeat (3) @(negedge clk);
        chk(pcount == 4, "R9", "bogus completion ignored", pcount, 4);
        retire(2, 2);
        @(negedge clk);
        chk(place_valid && place_cu == 2'd2, "R8", "placed right after release",
            int'(place_cu), 2);
        pl_cu.delete(2); pl_blk.delete(2);
        drain_all();
        chk(pcount == 5, "R2", "stalled launch blocks", pcount, 5);

        // R9: completion while idle
        retire(0, 0);
        @(negedge clk);
        chk(launch_ready && !launch_done, "R9", "idle completion ignored", int'(launch_done), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule